// File: doc/BRIEF.md
# Neuron Membrane-Potential Write Controller

This block sits on a stream of 512-bit host commands and handles only the command that sets one neuron's membrane potential. All other commands pass it by. The top byte of a command holds the operation code and the next byte holds the target core. A neuron-state write also carries a 16-bit neuron index and a signed 36-bit potential.

State memory is split into banks. Each 72-bit word packs two neurons side by side. The neuron index picks the bank with its bits above the local field. Inside the local field, bit 0 picks the half of the word and the remaining bits give the word address. A 36-bit half cannot be written on its own, so the block reads the word, replaces the target half, and writes all 72 bits back. The partner neuron keeps its value.

The command input uses a valid/ready handshake. Ready stays low for the whole read-modify-write, so a second command cannot reach a word in the middle of an update. Each bank has a plain synchronous port with a one-cycle read latency.

Top module: `neuron_state_writer`

## Requirements
- R1: After reset, `cmdReady` is 1, no bank enable or write enable is asserted, and `updateDone` is 0.
- R2: A command is taken for update when all three hold: bits [511:504] equal 8'h04, bits [503:496] equal `localCore`, and the neuron index in bits [495:480] is below 2^(LOCAL_BITS+BANK_BITS). In the cycle after acceptance, the block reads bank `index >> LOCAL_BITS` (enable 1, write 0) at word address `index[LOCAL_BITS-1:1]`. This is the only bank enabled.
- R3: Index bit 0 picks the half that is replaced: 0 selects word bits [35:0] and 1 selects bits [71:36]. The new half is the 36 bits [479:444], taken exactly as sent, sign bit included.
- R4: The half that is not selected is written back equal to the value read from memory. No other word in any bank changes.
- R5: The write-back happens exactly two cycles after the read cycle, to the same bank and address, with all 72 bits driven and only that bank enabled.
- R6: `cmdReady` is 0 from the read cycle through the write-back cycle. It is 1 again in the cycle after the write-back.
- R7: `updateDone` is 1 for exactly one cycle, the cycle after each write-back, and 0 at all other times.
- R8: A command with any opcode other than 8'h04 is accepted in one cycle. `cmdReady` stays 1, and the command causes no bank access and no `updateDone`.
- R9: A neuron-state write whose core byte differs from `localCore` is dropped in the same way as in R8.
- R10: A neuron-state write whose index has any bit set at or above position LOCAL_BITS+BANK_BITS is dropped in the same way as in R8.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rstN | input | 1 | Active-low synchronous reset |
| localCore | input | 8 | Core number this block answers to |
| cmdValid | input | 1 | Command word present |
| cmdReady | output | 1 | Block can take a command this cycle |
| cmdData | input | 512 | Command word |
| memEn | output | BANKS | Per-bank access enable |
| memWe | output | BANKS | Per-bank write enable (read when 0) |
| memAddr | output | BANKS*(LOCAL_BITS-1) | Per-bank word address, bank b at slice b |
| memWdata | output | BANKS*72 | Per-bank write word |
| memRdata | input | BANKS*72 | Per-bank read word, valid one cycle after a read |
| updateDone | output | 1 | One-cycle pulse after a completed write-back |

## Verification
Take the acceptance edge as cycle 0. The read request is due in cycle 1, the captured word sits in the merge register during cycle 2, the write-back is due in cycle 3, and `updateDone` rises with `cmdReady` in cycle 4. The bench drives at falling edges. After an accepted command it samples once at each of the next four falling edges and checks the signals due in that cycle. For a dropped command it checks at each of the following three falling edges that no bank was touched and that ready stayed high. It computes each expected write word from a reference copy of the memories.

// File: rtl/nsw_pkg.sv
package nsw_pkg;

  localparam int CMD_W    = 512;
  localparam int WORD_W   = 72;
  localparam int VOLT_W   = 36;
  localparam int ID_W     = 16;
  localparam int OP_HI    = 511;
  localparam int CORE_HI  = 503;
  localparam int ID_HI    = 495;
  localparam int VOLT_HI  = 479;
  localparam int VOLT_LO  = VOLT_HI - VOLT_W + 1;
  localparam logic [7:0] OP_STATE_WRITE = 8'h04;

  typedef enum logic [1:0] {
    ST_IDLE  = 2'd0,
    ST_READ  = 2'd1,
    ST_MERGE = 2'd2,
    ST_WRITE = 2'd3
  } nsw_state_e;

  typedef struct packed {
    logic capture;
    logic issueRead;
    logic captureWord;
    logic issueWrite;
  } nsw_strobe_t;

endpackage

// File: rtl/nsw_datapath.sv
module nsw_datapath
  import nsw_pkg::*;
#(
  parameter int LOCAL_BITS = 13,
  parameter int BANK_BITS  = 3,
  localparam int BANKS     = 1 << BANK_BITS,
  localparam int ADDR_W    = LOCAL_BITS - 1,
  localparam int USED_BITS = LOCAL_BITS + BANK_BITS
) (
  input  logic                      clk,
  input  logic                      rstN,
  input  nsw_strobe_t               strobe,
  input  logic [CMD_W-1:0]          cmdData,
  input  logic [7:0]                localCore,
  output logic                      cmdMine,
  output logic [BANKS-1:0]          memEn,
  output logic [BANKS-1:0]          memWe,
  output logic [BANKS*ADDR_W-1:0]   memAddr,
  output logic [BANKS*WORD_W-1:0]   memWdata,
  input  logic [BANKS*WORD_W-1:0]   memRdata
);

  logic [7:0]        cmdOp;
  logic [7:0]        cmdCore;
  logic [ID_W-1:0]   cmdId;
  logic [VOLT_W-1:0] cmdVolt;
  logic              idInRange;
  logic              unusedPayload;

  assign cmdOp         = cmdData[OP_HI -: 8];
  assign cmdCore       = cmdData[CORE_HI -: 8];
  assign cmdId         = cmdData[ID_HI -: ID_W];
  assign cmdVolt       = cmdData[VOLT_HI -: VOLT_W];
  assign unusedPayload = ^cmdData[VOLT_LO-1:0];

  generate
    if (USED_BITS < ID_W) begin : g_rangeCheck
      assign idInRange = ~|cmdId[ID_W-1:USED_BITS];
    end else begin : g_fullRange
      assign idInRange = 1'b1;
    end
  endgenerate

  assign cmdMine = (cmdOp == OP_STATE_WRITE) && (cmdCore == localCore) && idInRange;

  logic [BANK_BITS-1:0] bankReg;
  logic [ADDR_W-1:0]    addrReg;
  logic                 halfReg;
  logic [VOLT_W-1:0]    voltReg;
  logic [WORD_W-1:0]    mergedReg;
  logic [WORD_W-1:0]    rdSel;

  always_ff @(posedge clk) begin
    if (!rstN) begin
      bankReg <= '0;
      addrReg <= '0;
      halfReg <= 1'b0;
      voltReg <= '0;
    end else if (strobe.capture) begin
      bankReg <= cmdId[LOCAL_BITS +: BANK_BITS];
      addrReg <= cmdId[LOCAL_BITS-1:1];
      halfReg <= cmdId[0];
      voltReg <= cmdVolt;
    end
  end

  assign rdSel = memRdata[bankReg*WORD_W +: WORD_W];

  always_ff @(posedge clk) begin
    if (!rstN) begin
      mergedReg <= '0;
    end else if (strobe.captureWord) begin
      if (halfReg) mergedReg <= {voltReg, rdSel[VOLT_W-1:0]};
      else         mergedReg <= {rdSel[WORD_W-1:VOLT_W], voltReg};
    end
  end

  generate
    for (genvar b = 0; b < BANKS; b++) begin : g_bank
      logic hit;
      assign hit = (bankReg == BANK_BITS'(b));
      assign memEn[b]                        = (strobe.issueRead | strobe.issueWrite) & hit;
      assign memWe[b]                        = strobe.issueWrite & hit;
      assign memAddr[b*ADDR_W +: ADDR_W]     = addrReg;
      assign memWdata[b*WORD_W +: WORD_W]    = mergedReg;
    end
  endgenerate

  // R2 / R5: never more than one bank addressed at once
  a_r2_single_bank: assert property (@(posedge clk) disable iff (!rstN)
    $onehot0(memEn));

  // R5: a write-back is preceded two cycles earlier by a read
  a_r5_write_after_read: assert property (@(posedge clk) disable iff (!rstN)
    (|memWe) |-> $past((|memEn) && !(|memWe), 2));

  // R4: untouched half equals what memory returned
  a_r4_keep_upper: assert property (@(posedge clk) disable iff (!rstN)
    ((|memWe) && !halfReg) |->
      (memWdata[bankReg*WORD_W + VOLT_W +: WORD_W-VOLT_W] == $past(rdSel[WORD_W-1:VOLT_W])));

  a_r4_keep_lower: assert property (@(posedge clk) disable iff (!rstN)
    ((|memWe) && halfReg) |->
      (memWdata[bankReg*WORD_W +: VOLT_W] == $past(rdSel[VOLT_W-1:0])));

endmodule

// File: rtl/nsw_control.sv
module nsw_control
  import nsw_pkg::*;
(
  input  logic        clk,
  input  logic        rstN,
  input  logic        cmdValid,
  input  logic        cmdMine,
  output logic        cmdReady,
  output logic        updateDone,
  output nsw_strobe_t strobe
);

  nsw_state_e state;
  nsw_state_e stateNext;
  logic       accept;

  assign cmdReady = (state == ST_IDLE);
  assign accept   = cmdValid && cmdReady;

  always_comb begin
    stateNext = state;
    unique case (state)
      ST_IDLE:  if (accept && cmdMine) stateNext = ST_READ;
      ST_READ:  stateNext = ST_MERGE;
      ST_MERGE: stateNext = ST_WRITE;
      ST_WRITE: stateNext = ST_IDLE;
      default:  stateNext = ST_IDLE;
    endcase
  end

  always_ff @(posedge clk) begin
    if (!rstN) begin
      state      <= ST_IDLE;
      updateDone <= 1'b0;
    end else begin
      state      <= stateNext;
      updateDone <= (state == ST_WRITE);
    end
  end

  always_comb begin
    strobe             = '0;
    strobe.capture     = accept && cmdMine;
    strobe.issueRead   = (state == ST_READ);
    strobe.captureWord = (state == ST_MERGE);
    strobe.issueWrite  = (state == ST_WRITE);
  end

  // R6: ready drops right after an update is taken
  a_r6_busy_after_accept: assert property (@(posedge clk) disable iff (!rstN)
    (cmdValid && cmdReady && cmdMine) |=> !cmdReady);

  // R7: done is a single-cycle pulse
  a_r7_done_pulse: assert property (@(posedge clk) disable iff (!rstN)
    updateDone |=> !updateDone);

  // R8: a dropped command leaves the block ready
  a_r8_drop_stays_ready: assert property (@(posedge clk) disable iff (!rstN)
    (cmdValid && cmdReady && !cmdMine) |=> cmdReady);

endmodule

// File: rtl/neuron_state_writer.sv
module neuron_state_writer
  import nsw_pkg::*;
#(
  parameter int LOCAL_BITS = 13,
  parameter int BANK_BITS  = 3,
  localparam int BANKS     = 1 << BANK_BITS,
  localparam int ADDR_W    = LOCAL_BITS - 1
) (
  input  logic                      clk,
  input  logic                      rstN,
  input  logic [7:0]                localCore,
  input  logic                      cmdValid,
  output logic                      cmdReady,
  input  logic [CMD_W-1:0]          cmdData,
  output logic [BANKS-1:0]          memEn,
  output logic [BANKS-1:0]          memWe,
  output logic [BANKS*ADDR_W-1:0]   memAddr,
  output logic [BANKS*WORD_W-1:0]   memWdata,
  input  logic [BANKS*WORD_W-1:0]   memRdata,
  output logic                      updateDone
);

  nsw_strobe_t strobe;
  logic        cmdMine;

  nsw_control u_control (
    .clk        (clk),
    .rstN       (rstN),
    .cmdValid   (cmdValid),
    .cmdMine    (cmdMine),
    .cmdReady   (cmdReady),
    .updateDone (updateDone),
    .strobe     (strobe)
  );

  nsw_datapath #(
    .LOCAL_BITS (LOCAL_BITS),
    .BANK_BITS  (BANK_BITS)
  ) u_datapath (
    .clk       (clk),
    .rstN      (rstN),
    .strobe    (strobe),
    .cmdData   (cmdData),
    .localCore (localCore),
    .cmdMine   (cmdMine),
    .memEn     (memEn),
    .memWe     (memWe),
    .memAddr   (memAddr),
    .memWdata  (memWdata),
    .memRdata  (memRdata)
  );

  // R1: nothing touches memory while ready and not yet busy
  a_r1_idle_quiet: assert property (@(posedge clk) disable iff (!rstN)
    (cmdReady && !$past(cmdValid && cmdReady && cmdMine)) |-> (memEn == '0));

endmodule

// File: tb/tb_neuron_state_writer.sv
`timescale 1ns/1ps
module tb_neuron_state_writer;

  localparam int LB     = 4;
  localparam int BB     = 2;
  localparam int NB     = 1 << BB;
  localparam int AW     = LB - 1;
  localparam int WORDS  = 1 << AW;
  localparam int NIDS   = 1 << (LB + BB);
  localparam logic [7:0] MYCORE = 8'h05;

  logic              clk = 1'b0;
  logic              rstN = 1'b0;
  logic              cmdValid = 1'b0;
  logic              cmdReady;
  logic [511:0]      cmdData = '0;
  logic [NB-1:0]     memEn, memWe;
  logic [NB*AW-1:0]  memAddr;
  logic [NB*72-1:0]  memWdata;
  logic [NB*72-1:0]  memRdata;
  logic              updateDone;

  int checks = 0;
  int fails = 0;
  bit finished = 0;

  always #4 clk = ~clk;

  neuron_state_writer #(.LOCAL_BITS(LB), .BANK_BITS(BB)) dut (
    .clk(clk), .rstN(rstN), .localCore(MYCORE),
    .cmdValid(cmdValid), .cmdReady(cmdReady), .cmdData(cmdData),
    .memEn(memEn), .memWe(memWe), .memAddr(memAddr),
    .memWdata(memWdata), .memRdata(memRdata), .updateDone(updateDone)
  );

  function automatic logic [71:0] initWord(int b, int w);
    return {8'(b), 8'(w), 56'hC3_5A0F_9966_1E2D} ^ (72'(b * 8 + w) * 72'h1_0003_0507);
  endfunction

  logic [71:0] bankMem [NB][WORDS];
  logic [71:0] refMem  [NB][WORDS];
  logic [71:0] rdReg   [NB];

  always_ff @(posedge clk) begin
    for (int b = 0; b < NB; b++) begin
      if (!rstN) begin
        for (int w = 0; w < WORDS; w++) bankMem[b][w] <= initWord(b, w);
        rdReg[b] <= '0;
      end else if (memEn[b]) begin
        if (memWe[b]) bankMem[b][memAddr[b*AW +: AW]] <= memWdata[b*72 +: 72];
        else          rdReg[b] <= bankMem[b][memAddr[b*AW +: AW]];
      end
    end
  end

  always_comb begin
    for (int b = 0; b < NB; b++) memRdata[b*72 +: 72] = rdReg[b];
  end

  task automatic chk(input bit ok, input string tag, input logic [71:0] act, input logic [71:0] exp);
    checks++;
    if (!ok) begin
      fails++;
      $display("FAIL %s actual=%h expected=%h", tag, act, exp);
    end
  endtask

  function automatic logic [511:0] mkCmd(logic [7:0] op, logic [7:0] core, logic [15:0] id, logic [35:0] v);
    return {op, core, id, v, 444'd0};
  endfunction

  // send an update expected to be taken; checks each cycle of the sequence
  task automatic sendUpdate(input int id, input logic [35:0] v);
    int b = id >> LB;
    int w = (id % (1 << LB)) >> 1;
    logic [71:0] exp;
    exp = (id % 2) ? {v, refMem[b][w][35:0]} : {refMem[b][w][71:36], v};
    @(negedge clk);
    chk(cmdReady, "R6 ready before", 72'(cmdReady), 72'd1);
    cmdValid = 1'b1;
    cmdData  = mkCmd(8'h04, MYCORE, 16'(id), v);
    @(negedge clk);
    cmdValid = 1'b0;
    chk(memEn == NB'(1 << b) && memWe == '0, "R2 read bank", 72'({memEn, memWe}), 72'({NB'(1 << b), NB'(0)}));
    chk(memAddr[b*AW +: AW] == AW'(w), "R2 read addr", 72'(memAddr[b*AW +: AW]), 72'(w));
    chk(!cmdReady, "R6 busy read", 72'(cmdReady), 72'd0);
    @(negedge clk);
    chk(!cmdReady && memEn == '0, "R6 busy merge", 72'({cmdReady, memEn}), 72'd0);
    @(negedge clk);
    chk(memEn == NB'(1 << b) && memWe == NB'(1 << b), "R5 write bank", 72'({memEn, memWe}), 72'({NB'(1 << b), NB'(1 << b)}));
    chk(memAddr[b*AW +: AW] == AW'(w), "R5 write addr", 72'(memAddr[b*AW +: AW]), 72'(w));
    chk(memWdata[b*72 +: 72] == exp, "R3 R4 write word", memWdata[b*72 +: 72], exp);
    chk(!cmdReady && !updateDone, "R6 busy write", 72'({cmdReady, updateDone}), 72'd0);
    @(negedge clk);
    chk(updateDone && cmdReady && memEn == '0, "R7 done pulse", 72'({updateDone, cmdReady, memEn}), 72'({2'b11, NB'(0)}));
    @(negedge clk);
    chk(!updateDone, "R7 done single", 72'(updateDone), 72'd0);
    refMem[b][w] = exp;
  endtask

  // send a command that must be passed over
  task automatic sendDrop(input logic [7:0] op, input logic [7:0] core, input logic [15:0] id, input string tag);
    @(negedge clk);
    cmdValid = 1'b1;
    cmdData  = mkCmd(op, core, id, 36'h8_1234_5678);
    @(negedge clk);
    cmdValid = 1'b0;
    for (int k = 0; k < 3; k++) begin
      chk(cmdReady && memEn == '0 && !updateDone, tag, 72'({cmdReady, updateDone, memEn}), 72'({2'b10, NB'(0)}));
      @(negedge clk);
    end
  endtask

  initial begin
    for (int b = 0; b < NB; b++)
      for (int w = 0; w < WORDS; w++) refMem[b][w] = initWord(b, w);
    repeat (3) @(negedge clk);
    rstN = 1'b1;
    @(negedge clk);
    chk(cmdReady && memEn == '0 && memWe == '0 && !updateDone, "R1 reset state",
        72'({cmdReady, updateDone, memEn, memWe}), 72'({2'b10, NB'(0), NB'(0)}));

    // exhaustive sweep over every neuron, two passes, odd ids negative
    for (int p = 0; p < 2; p++)
      for (int id = 0; id < NIDS; id++)
        sendUpdate(id, 36'(id * 977 + p * 31) ^ ((id % 2) ? 36'h8_0000_0000 : 36'h0));
    sendUpdate(0, 36'h8_0000_0000);
    sendUpdate(NIDS - 1, 36'h7_FFFF_FFFF);
    sendUpdate(NIDS - 2, 36'hF_FFFF_FFFF);

    for (int op = 0; op < 256; op++)
      if (op != 4) sendDrop(8'(op), MYCORE, 16'd3, "R8 other opcode");
    sendDrop(8'h04, 8'h06, 16'd3, "R9 core mismatch");
    sendDrop(8'h04, 8'h00, 16'd5, "R9 core mismatch");
    sendDrop(8'h04, 8'hFF, 16'd9, "R9 core mismatch");
    sendDrop(8'h04, MYCORE, 16'(NIDS), "R10 index out of range");
    sendDrop(8'h04, MYCORE, 16'hFFFF, "R10 index out of range");
    sendDrop(8'h04, MYCORE, 16'h8001, "R10 index out of range");

    @(negedge clk);
    for (int b = 0; b < NB; b++)
      for (int w = 0; w < WORDS; w++)
        chk(bankMem[b][w] == refMem[b][w], "R4 final memory", bankMem[b][w], refMem[b][w]);

    if (!finished) begin
      finished = 1;
      $display("%0d/%0d checks passed", checks - fails, checks);
      $finish;
    end
  end

  initial begin
    repeat (150000) @(posedge clk);
    if (!finished) begin
      finished = 1;
      checks++;
      fails++;
      $display("FAIL watchdog expired");
      $display("%0d/%0d checks passed", checks - fails, checks);
      $finish;
    end
  end

endmodule